// File: doc/BRIEF.md
# ADC Result Threshold Monitor

This block sits behind an analog-to-digital converter and watches the stream of 12-bit conversion results it produces. Each result arrives with a valid strobe and the number of the channel it belongs to. The block keeps the most recent result of every channel in a register of its own, and any of them can be read back through a channel-select read port.

Every channel has a low threshold, a high threshold and a 2-bit watch mode. In window mode a result below the low threshold or above the high threshold raises the channel's flag. In the two crossing modes the block compares each result with the previous result of the same channel. A rising crossing passes upward through the high threshold. A falling crossing passes downward through the low threshold. Flags are sticky and a write of ones clears them. A single interrupt line combines the flags of all channels that are not switched off.

Software programs thresholds and modes and clears flags through a one-cycle write interface: a write strobe, a 2-bit register kind, a channel index and a 12-bit data word.

Top module: `adc_window_monitor`

## Requirements
- R1: After reset all flags and the interrupt are 0, every latest-result register reads 0, every mode is off (0), every low threshold is 0 and every high threshold is 4095.
- R2: When a valid result arrives, that channel's latest-result register holds the value from the next clock edge onward. `rd_result` shows the register selected by `rd_chan`, and no other channel's register changes.
- R3: In window mode (mode code 1), a result strictly below the low threshold or strictly above the high threshold sets the channel's flag. A result equal to either threshold does not. The flag is visible one cycle after the result's valid cycle.
- R4: In rising mode (mode code 2), the flag is set when the previous result of the channel was below the high threshold and the current result is at or above it.
- R5: In falling mode (mode code 3), the flag is set when the previous result was at or above the low threshold and the current result is below it.
- R6: The first result a channel receives after reset, or after any write to its mode, never produces a crossing event.
- R7: In off mode (mode code 0), results update the latest-result register but never set the flag.
- R8: A flag stays set until a clear write. A clear write has register kind 3, and bit i of `cfg_wdata` clears the flag of channel i. Writes with kind 0, 1 and 2 load the low threshold, the high threshold and the mode (`cfg_wdata[1:0]`) of channel `cfg_chan`.
- R9: When an event on a channel and a clear of that channel's flag happen in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when some channel whose mode is not off has its flag set. Switching a channel off masks its flag from `irq` but does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A conversion result is present this cycle |
| smp_chan | input | 3 | Channel of the result |
| smp_value | input | 12 | Conversion result |
| cfg_we | input | 1 | Register write strobe |
| cfg_kind | input | 2 | 0 low threshold, 1 high threshold, 2 mode, 3 flag clear |
| cfg_chan | input | 3 | Channel addressed by kinds 0 to 2 |
| cfg_wdata | input | 12 | Write data (threshold, mode in bits 1:0, or clear mask) |
| rd_chan | input | 3 | Channel whose latest result is shown |
| rd_result | output | 12 | Latest result of channel `rd_chan` |
| flags | output | 8 | Sticky per-channel event flags |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check the flag rules: stickiness, clearing, set-over-clear priority, silence in off mode, and silence on the first sample of a crossing mode. They also check that the latest result is captured, that at most one channel is addressed per cycle, and that the interrupt rises only after a sample or a write. The bench scenarios are needed for the comparison edges: values equal to a threshold, a second upward step that must not fire again, and a large jump right after a mode rewrite. They also cover readback through the read port and the masking of a kept flag when its channel is switched off and on again.

// File: rtl/awm_pkg.sv
package awm_pkg;

  localparam int RES_W = 12;

  typedef enum logic [1:0] {
    WATCH_OFF    = 2'd0,
    WATCH_WINDOW = 2'd1,
    WATCH_RISE   = 2'd2,
    WATCH_FALL   = 2'd3
  } watch_mode_e;

  typedef enum logic [1:0] {
    KIND_LOW   = 2'd0,
    KIND_HIGH  = 2'd1,
    KIND_MODE  = 2'd2,
    KIND_CLEAR = 2'd3
  } cfg_kind_e;

  // Value lies outside the closed interval [lo, hi].
  function automatic logic beyond_window(input logic [RES_W-1:0] v,
                                         input logic [RES_W-1:0] lo,
                                         input logic [RES_W-1:0] hi);
    return (v < lo) || (v > hi);
  endfunction

  // Previous sample under the level, current one at or over it.
  function automatic logic went_up(input logic [RES_W-1:0] prev,
                                   input logic [RES_W-1:0] cur,
                                   input logic [RES_W-1:0] level);
    return (prev < level) && (cur >= level);
  endfunction

  // Previous sample at or over the level, current one under it.
  function automatic logic went_down(input logic [RES_W-1:0] prev,
                                     input logic [RES_W-1:0] cur,
                                     input logic [RES_W-1:0] level);
    return (prev >= level) && (cur < level);
  endfunction

endpackage

// File: rtl/awm_cfg_decode.sv
module awm_cfg_decode
  import awm_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [CHW-1:0]   smp_chan,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [CHW-1:0]   cfg_chan,
  input  logic [RES_W-1:0] cfg_wdata,
  output logic [NCH-1:0]   hit_vec,
  output logic [NCH-1:0]   wr_lo_vec,
  output logic [NCH-1:0]   wr_hi_vec,
  output logic [NCH-1:0]   wr_mode_vec,
  output logic [NCH-1:0]   clr_vec
);

  logic do_lo, do_hi, do_mode, do_clr;

  assign do_lo   = cfg_we && (cfg_kind == KIND_LOW);
  assign do_hi   = cfg_we && (cfg_kind == KIND_HIGH);
  assign do_mode = cfg_we && (cfg_kind == KIND_MODE);
  assign do_clr  = cfg_we && (cfg_kind == KIND_CLEAR);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    localparam logic [CHW-1:0] IDX = CHW'(i);
    assign hit_vec[i]     = smp_valid && (smp_chan == IDX);
    assign wr_lo_vec[i]   = do_lo   && (cfg_chan == IDX);
    assign wr_hi_vec[i]   = do_hi   && (cfg_chan == IDX);
    assign wr_mode_vec[i] = do_mode && (cfg_chan == IDX);
    if (i < RES_W) begin : g_mask
      assign clr_vec[i] = do_clr && cfg_wdata[i];
    end else begin : g_nomask
      assign clr_vec[i] = 1'b0;
    end
  end

  // R2: one result never lands in two channels
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R8: a threshold or mode write reaches at most one channel
  p_one_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_lo_vec | wr_hi_vec | wr_mode_vec));

endmodule

// File: rtl/awm_slot.sv
module awm_slot
  import awm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_hit,
  input  logic [RES_W-1:0] smp_value,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic             wr_mode,
  input  logic [RES_W-1:0] wdata,
  input  logic             clr,
  output logic             flag,
  output logic             mode_on,
  output logic [RES_W-1:0] latest
);

  logic [RES_W-1:0] lo_q, hi_q, latest_q;
  watch_mode_e      mode_q;
  logic             seen_q;
  logic             flag_q;
  logic             cond_w;
  logic             hit_event;

  always_comb begin
    unique case (mode_q)
      WATCH_WINDOW: cond_w = beyond_window(smp_value, lo_q, hi_q);
      WATCH_RISE:   cond_w = seen_q && went_up(latest_q, smp_value, hi_q);
      WATCH_FALL:   cond_w = seen_q && went_down(latest_q, smp_value, lo_q);
      default:      cond_w = 1'b0;
    endcase
  end

  assign hit_event = smp_hit && cond_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '1;
      mode_q   <= WATCH_OFF;
      latest_q <= '0;
      seen_q   <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_lo)   lo_q   <= wdata;
      if (wr_hi)   hi_q   <= wdata;
      if (wr_mode) mode_q <= watch_mode_e'(wdata[1:0]);
      if (smp_hit) latest_q <= smp_value;
      if (wr_mode)      seen_q <= 1'b0;
      else if (smp_hit) seen_q <= 1'b1;
      flag_q <= hit_event || (flag_q && !clr);
    end
  end

  assign flag    = flag_q;
  assign mode_on = (mode_q != WATCH_OFF);
  assign latest  = latest_q;

  // R2: the accepted result is what the register holds afterwards
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_hit |=> (latest == $past(smp_value)));

  // R3: an out-of-window result in window mode leaves the flag set
  p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_hit && mode_q == WATCH_WINDOW && (smp_value < lo_q || smp_value > hi_q)) |=> flag);

  // R6: no crossing without a previous sample
  p_first_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_hit && !seen_q && (mode_q == WATCH_RISE || mode_q == WATCH_FALL) && !flag && !wr_mode) |=> !flag);

  // R7: off mode never raises a flag
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_hit && mode_q == WATCH_OFF && !flag) |=> !flag);

  // R8: flag holds without a clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  // R8: a clear without an event drops the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && clr && !hit_event) |=> !flag);

  // R9: an event beats a simultaneous clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_event && clr) |=> flag);

endmodule

// File: rtl/awm_irq_merge.sv
module awm_irq_merge #(
  parameter int NCH = 8
) (
  input  logic [NCH-1:0] flag_vec,
  input  logic [NCH-1:0] on_vec,
  output logic           irq
);

  logic [NCH-1:0] live;

  for (genvar i = 0; i < NCH; i++) begin : g_live
    assign live[i] = flag_vec[i] && on_vec[i];
  end

  assign irq = |live;

endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor
  import awm_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [CHW-1:0]   smp_chan,
  input  logic [RES_W-1:0] smp_value,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_kind,
  input  logic [CHW-1:0]   cfg_chan,
  input  logic [RES_W-1:0] cfg_wdata,
  input  logic [CHW-1:0]   rd_chan,
  output logic [RES_W-1:0] rd_result,
  output logic [NCH-1:0]   flags,
  output logic             irq
);

  logic [NCH-1:0]   hit_vec, wr_lo_vec, wr_hi_vec, wr_mode_vec, clr_vec;
  logic [NCH-1:0]   flag_vec, on_vec;
  logic [RES_W-1:0] latest_arr [NCH];

  awm_cfg_decode #(.NCH(NCH)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_chan   (smp_chan),
    .cfg_we     (cfg_we),
    .cfg_kind   (cfg_kind),
    .cfg_chan   (cfg_chan),
    .cfg_wdata  (cfg_wdata),
    .hit_vec    (hit_vec),
    .wr_lo_vec  (wr_lo_vec),
    .wr_hi_vec  (wr_hi_vec),
    .wr_mode_vec(wr_mode_vec),
    .clr_vec    (clr_vec)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    awm_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_hit  (hit_vec[i]),
      .smp_value(smp_value),
      .wr_lo    (wr_lo_vec[i]),
      .wr_hi    (wr_hi_vec[i]),
      .wr_mode  (wr_mode_vec[i]),
      .wdata    (cfg_wdata),
      .clr      (clr_vec[i]),
      .flag     (flag_vec[i]),
      .mode_on  (on_vec[i]),
      .latest   (latest_arr[i])
    );
  end

  awm_irq_merge #(.NCH(NCH)) u_irq (
    .flag_vec(flag_vec),
    .on_vec  (on_vec),
    .irq     (irq)
  );

  always_comb begin
    rd_result = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_chan == CHW'(i)) rd_result = latest_arr[i];
    end
  end

  assign flags = flag_vec;

  // R10: the interrupt only rises after a result or a register write
  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(smp_valid || cfg_we));

  // R10: a raised interrupt always has a flag behind it
  p_irq_backed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0));

endmodule

// File: tb/sim_adc_window_monitor.sv
`timescale 1ns/1ps
module sim_adc_window_monitor;

  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [2:0]  smp_chan = '0;
  logic [11:0] smp_value = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [2:0]  cfg_chan = '0;
  logic [11:0] cfg_wdata = '0;
  logic [2:0]  rd_chan = '0;
  logic [11:0] rd_result;
  logic [7:0]  flags;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state, from the requirements
  int   m_lo   [NCH];
  int   m_hi   [NCH];
  int   m_mode [NCH];
  int   m_last [NCH];
  bit   m_seen [NCH];
  logic [7:0] m_flags;

  always #4 clk = ~clk;

  adc_window_monitor #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_value(smp_value),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata),
    .rd_chan(rd_chan), .rd_result(rd_result), .flags(flags), .irq(irq)
  );

  function automatic bit model_event(int ch, int v);
    int p;
    p = m_last[ch];
    case (m_mode[ch])
      1: return !(v >= m_lo[ch] && v <= m_hi[ch]);
      2: return m_seen[ch] && (p < m_hi[ch]) && !(v < m_hi[ch]);
      3: return m_seen[ch] && !(p < m_lo[ch]) && (v < m_lo[ch]);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic model_irq();
    logic r;
    r = 1'b0;
    for (int i = 0; i < NCH; i++) if (m_flags[i] && m_mode[i] != 0) r = 1'b1;
    return r;
  endfunction

  task automatic check_val(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(string req);
    check_val(req, "flags", int'(flags), int'(m_flags));
    check_val(req, "irq", int'(irq), int'(model_irq()));
  endtask

  // one cycle with an optional result and an optional register write
  task automatic cycle(bit sv, int sch, int sval, bit we, int kind, int cch, int wd);
    bit ev;
    ev = sv ? model_event(sch, sval) : 1'b0;
    smp_valid = sv; smp_chan = 3'(sch); smp_value = 12'(sval);
    cfg_we = we; cfg_kind = 2'(kind); cfg_chan = 3'(cch); cfg_wdata = 12'(wd);
    @(negedge clk);
    smp_valid = 1'b0; cfg_we = 1'b0;
    if (we && kind == 3) m_flags = m_flags & ~8'(wd);
    if (ev) m_flags[sch] = 1'b1;
    if (sv) begin m_last[sch] = sval; m_seen[sch] = 1'b1; end
    if (we) begin
      case (kind)
        0: m_lo[cch] = wd;
        1: m_hi[cch] = wd;
        2: begin m_mode[cch] = wd & 3; m_seen[cch] = 1'b0; end
        default: ;
      endcase
    end
  endtask

  task automatic sample(int ch, int v);
    cycle(1'b1, ch, v, 1'b0, 0, 0, 0);
  endtask

  task automatic wr(int kind, int ch, int wd);
    cycle(1'b0, 0, 0, 1'b1, kind, ch, wd);
  endtask

  task automatic t_reset();
    check_state("R1");
    for (int i = 0; i < NCH; i++) begin
      rd_chan = 3'(i);
      #1;
      check_val("R1", "latest after reset", int'(rd_result), 0);
    end
    // default thresholds 0..4095: window mode flags nothing
    wr(2, 7, 1);
    sample(7, 0);
    sample(7, 4095);
    check_state("R1");
    wr(2, 7, 0);
  endtask

  task automatic t_latest();
    sample(5, 12'hABC);
    sample(6, 12'h123);
    rd_chan = 3'd5; #1;
    check_val("R2", "latest ch5", int'(rd_result), 12'hABC);
    rd_chan = 3'd6; #1;
    check_val("R2", "latest ch6", int'(rd_result), 12'h123);
    rd_chan = 3'd4; #1;
    check_val("R2", "untouched ch4", int'(rd_result), 0);
  endtask

  task automatic t_window();
    wr(0, 0, 100); wr(1, 0, 200); wr(2, 0, 1);
    sample(0, 100); check_state("R3");
    sample(0, 200); check_state("R3");
    sample(0, 99);  check_state("R3");
    check_val("R3", "ch0 flag below low", int'(flags[0]), 1);
    wr(3, 0, 1);    check_state("R8");
    check_val("R8", "ch0 flag cleared", int'(flags[0]), 0);
    sample(0, 201); check_state("R3");
    sample(0, 150); check_state("R8");
    check_val("R8", "ch0 flag sticky", int'(flags[0]), 1);
    wr(3, 0, 1);
  endtask

  task automatic t_rise();
    wr(1, 1, 1000); wr(2, 1, 2);
    sample(1, 500);  check_state("R6");
    sample(1, 999);  check_state("R4");
    sample(1, 1000); check_state("R4");
    check_val("R4", "ch1 rising at level", int'(flags[1]), 1);
    wr(3, 0, 2);
    sample(1, 1500); check_state("R4");
    check_val("R4", "no second rise", int'(flags[1]), 0);
    sample(1, 900);  check_state("R4");
    sample(1, 4095); check_state("R4");
    wr(3, 0, 2);
  endtask

  task automatic t_fall();
    wr(0, 2, 300); wr(2, 2, 3);
    sample(2, 400); check_state("R5");
    sample(2, 300); check_state("R5");
    check_val("R5", "equal to level no fall", int'(flags[2]), 0);
    sample(2, 299); check_state("R5");
    check_val("R5", "ch2 falling", int'(flags[2]), 1);
    wr(3, 0, 4);
    sample(2, 100); check_state("R5");
    sample(2, 300); check_state("R5");
    sample(2, 0);   check_state("R5");
    wr(3, 0, 4);
  endtask

  task automatic t_first();
    wr(1, 3, 50);
    sample(3, 10);
    wr(2, 3, 2);
    sample(3, 4000); check_state("R6");
    check_val("R6", "no cross after mode write", int'(flags[3]), 0);
    sample(3, 10);   check_state("R6");
    sample(3, 60);   check_state("R4");
    check_val("R4", "ch3 rises once history exists", int'(flags[3]), 1);
    wr(3, 0, 8);
  endtask

  task automatic t_off();
    wr(0, 4, 100); wr(1, 4, 200);
    sample(4, 4095); check_state("R7");
    sample(4, 0);    check_state("R7");
    check_val("R7", "off channel flag", int'(flags[4]), 0);
    rd_chan = 3'd4; #1;
    check_val("R7", "off channel still stores", int'(rd_result), 0);
    sample(4, 77);
    #1;
    check_val("R7", "off channel latest", int'(rd_result), 77);
  endtask

  task automatic t_setwins();
    sample(0, 50); check_state("R3");
    cycle(1'b1, 0, 250, 1'b1, 3, 0, 1); check_state("R9");
    check_val("R9", "set beats clear", int'(flags[0]), 1);
    cycle(1'b1, 0, 150, 1'b1, 3, 0, 1); check_state("R8");
    check_val("R8", "clear with quiet sample", int'(flags[0]), 0);
  endtask

  task automatic t_irqmask();
    sample(0, 10);
    check_val("R10", "irq with live flag", int'(irq), 1);
    wr(2, 0, 0); check_state("R10");
    check_val("R10", "irq masked when off", int'(irq), 0);
    check_val("R10", "flag kept when off", int'(flags[0]), 1);
    wr(2, 0, 1); check_state("R10");
    check_val("R10", "irq back when on", int'(irq), 1);
    wr(3, 0, 8'hFF); check_state("R8");
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_lo[i] = 0; m_hi[i] = 4095; m_mode[i] = 0; m_last[i] = 0; m_seen[i] = 1'b0;
    end
    m_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latest();
    t_window();
    t_rise();
    t_fall();
    t_first();
    t_off();
    t_setwins();
    t_irqmask();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule